// File: doc/BRIEF.md
# Shift-Register Byte FIFO

A small first-in first-out byte buffer whose storage is a chain of sixteen byte registers rather than a RAM. Every accepted write shifts the whole chain one place deeper and places the new byte at the shallow end. The oldest byte therefore sits at a depth equal to the number of stored bytes minus one. An up/down counter tracks that depth, and the read port is a multiplexer that selects the chain stage the counter names.

The writer drives a push strobe with a byte. The reader watches the empty flag, raises a pop strobe, and takes the byte on the read port. After the clock edge that accepts a pop, the read port shows the next oldest byte with no added register delay. A full flag tells the writer to hold off. Both sides share one clock and one synchronous active-high reset.

The empty state is coded as the counter at all ones with a separate empty bit set. With that bit the block can tell all seventeen fill levels (0 to 16) apart using a four-bit counter.

Top module: `byte_shift_fifo`

## Requirements
- R1: After synchronous reset, empty is 1 and full is 0, whatever the storage holds.
- R2: Bytes leave the read port in the order they were accepted by push, with no loss or duplication.
- R3: A push into an empty buffer clears empty at that clock edge, and the pushed byte is on the read port right after it.
- R4: Occupancy goes up by one on a push-only cycle and down by one on a pop-only cycle. Full is 1 exactly when 16 bytes are held, and empty and full are never both 1.
- R5: A push while full is ignored. Full stays 1 and the 16 stored bytes are later read out unchanged and in order.
- R6: A pop while empty is ignored. Empty stays 1 and later traffic behaves as from a freshly emptied buffer.
- R7: Push and pop in the same cycle on a buffer that is neither empty nor full keep the occupancy the same, and the read port moves on to the next oldest byte.
- R8: Push and pop in the same cycle on an empty buffer act as a push alone.
- R9: A pop that takes the only stored byte sets empty at that clock edge.
- R10: The read port always shows the oldest stored byte while the buffer is not empty, including in the cycle right after a pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write strobe, taken on the rising edge |
| push_data | input | DATA_W | Byte to write |
| pop | input | 1 | Read strobe, taken on the rising edge |
| pop_data | output | DATA_W | Oldest stored byte (combinational tap) |
| empty | output | 1 | No bytes held |
| full | output | 1 | DEPTH bytes held |

## Verification
The bench first steps through every fill level from zero to sixteen, filling to that level and draining again. This checks the flag coding at each counter value, including the wrap of the counter from all ones to zero and back. Directed patterns then separate the special cases that a simple up/down count would mix up: a pop on empty, a push on full, a push and pop together on empty, and a push and pop together at a middle level. Long random runs with push-heavy, pop-heavy and balanced mixes compare every popped byte with a reference queue. The push-heavy runs keep the buffer at full and the pop-heavy runs keep it at empty.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } fsr_op_e;

  // Classify the accepted work of one cycle
  function automatic fsr_op_e fsr_decode(input logic take_in, input logic give_out);
    fsr_op_e op;
    unique case ({give_out, take_in})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/sr_store.sv
module sr_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] stage [DEPTH];

  // Stage 0 takes the new byte; every deeper stage takes its neighbour.
  // No reset: the chain maps onto shift-register primitives.
  always_ff @(posedge clk) begin
    if (shift_en) stage[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (shift_en) stage[g] <= stage[g-1];
    end
  end

  assign rd_data = stage[rd_idx];

endmodule

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import fsr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic [AW-1:0] cnt,
  output logic          empty,
  output logic          full,
  output logic          shift_en
);

  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic [AW-1:0] cnt_q;
  logic          empty_q;
  logic          take_ok, give_ok;
  fsr_op_e       op;

  assign full    = !empty_q && (cnt_q == TOP);
  assign take_ok = push_req && !full;
  assign give_ok = pop_req && !empty_q;
  assign op      = fsr_decode(take_ok, give_ok);
  assign shift_en = take_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= TOP;
      empty_q <= 1'b1;
    end else begin
      unique case (op)
        OP_PUSH: begin
          cnt_q   <= cnt_q + 1'b1;   // all ones wraps to zero on first byte
          empty_q <= 1'b0;
        end
        OP_POP: begin
          cnt_q <= cnt_q - 1'b1;     // zero wraps to all ones on last byte
          if (cnt_q == '0) empty_q <= 1'b1;
        end
        default: ;                   // idle or swap: depth holds
      endcase
    end
  end

  assign cnt   = cnt_q;
  assign empty = empty_q;

endmodule

// File: rtl/byte_shift_fifo.sv
module byte_shift_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic              full
);

  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] cnt_q;
  logic          shift_en;

  occ_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_req (push),
    .pop_req  (pop),
    .cnt      (cnt_q),
    .empty    (empty),
    .full     (full),
    .shift_en (shift_en)
  );

  sr_store #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .shift_en (shift_en),
    .din      (push_data),
    .rd_idx   (cnt_q),
    .rd_data  (pop_data)
  );

endmodule

// File: rtl/fifo_checker.sv
module fifo_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          push,
  input logic          pop,
  input logic          empty,
  input logic          full,
  input logic [DW-1:0] rd_data,
  input logic [AW-1:0] cnt
);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  p_push_clears_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (empty && push) |=> !empty);

  p_pop_empty_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);

  p_full_push_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(rd_data)));

  p_swap_keeps_depth_r7: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && push && pop) |=> (!empty && $stable(cnt)));

  p_last_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (!empty && cnt == '0 && pop && !push) |=> empty);

endmodule

bind byte_shift_fifo fifo_checker #(.DW(DATA_W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .push    (push),
  .pop     (pop),
  .empty   (empty),
  .full    (full),
  .rd_data (pop_data),
  .cnt     (cnt_q)
);

// File: tb/tb_byte_shift_fifo.sv
module tb_byte_shift_fifo;

  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic          empty, full;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] model_q [$];

  always #4 clk = ~clk;   // 125 MHz

  byte_shift_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .empty(empty), .full(full)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check head before the edge, flags after it
  task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
    bit tk, gv;
    @(negedge clk);
    push = p; pop = q; push_data = d;
    tk = p && (model_q.size() < DEPTH);
    gv = q && (model_q.size() > 0);
    #1;
    if (gv) check("R2 R10 head", pop_data, model_q[0]);
    @(posedge clk);
    #1;
    if (gv) void'(model_q.pop_front());
    if (tk) model_q.push_back(d);
    check("R4 empty", empty, model_q.size() == 0);
    check("R4 full", full, model_q.size() == DEPTH);
    if (model_q.size() > 0) check("R10 head after edge", pop_data, model_q[0]);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);

    // R6 pop on empty ignored
    step(0, 1, 8'h00);
    check("R6 still empty", empty, 1);
    // R3 push into empty
    step(1, 0, 8'hA5);
    check("R3 empty cleared", empty, 0);
    check("R3 head", pop_data, 8'hA5);
    // R9 last pop
    step(0, 1, 8'h00);
    check("R9 empty set", empty, 1);

    // R4 sweep every fill level, then drain
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int k = 0; k < lvl; k++) step(1, 0, DW'(lvl * 17 + k));
      check("R4 level full", full, lvl == DEPTH);
      for (int k = 0; k < lvl; k++) step(0, 1, 8'h00);
      check("R9 drained", empty, 1);
    end

    // R5 push on full ignored
    for (int k = 0; k < DEPTH; k++) step(1, 0, DW'(8'h40 + k));
    step(1, 0, 8'hEE);
    check("R5 full kept", full, 1);
    check("R5 head kept", pop_data, 8'h40);
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 1, 8'h00);
    end
    check("R5 drained empty", empty, 1);

    // R8 push+pop on empty = push
    step(1, 1, 8'h3C);
    check("R8 not empty", empty, 0);
    check("R8 head", pop_data, 8'h3C);

    // R7 swap at middle level
    step(1, 0, 8'h11);
    step(1, 0, 8'h22);
    step(1, 1, 8'h33);
    check("R7 size", model_q.size(), 3);
    check("R7 head moved", pop_data, 8'h11);
    while (model_q.size() > 0) step(0, 1, 8'h00);

    // R2 random traffic: push-heavy, pop-heavy, balanced
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 2000; c++) begin
        int r = int'($urandom_range(0, 99));
        logic p = (ph == 0) ? (r < 75) : (ph == 1) ? (r < 25) : (r < 50);
        logic q = ($urandom_range(0, 99) < ((ph == 0) ? 25 : (ph == 1) ? 75 : 50));
        step(p, q, DW'($urandom));
      end
    end
    while (model_q.size() > 0) step(0, 1, 8'h00);
    check("R2 final empty", empty, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule